// File: doc/BRIEF.md
# Pipelined Saturating Add-Compare-Select Unit

This unit performs one add-compare-select step of a trellis decoder on each valid cycle. It takes two predecessor path metrics, an upper one and a lower one, each with a branch metric. It forms the two candidate metrics with saturating addition. It keeps the smaller candidate and reports a decision bit that names the winning predecessor. Operations can be issued back to back, and each result leaves the unit a fixed number of cycles after its operands went in.

The first pipeline stage checks whether either predecessor metric already sits at the saturation ceiling (all ones). A predecessor at the ceiling cannot win, so the outcome is settled at that point. The adder of each saturated candidate has its operands forced to zero, and the magnitude comparator is held idle. A gating flag travels with the result to mark the operations that took this shortcut.

Top module: `acs_pipe_unit`

## Requirements
- R1: A result appears on `out_valid` exactly 8 clock cycles after its operands are accepted on `in_valid`, and one result appears for every accepted operation.
- R2: A candidate metric is the predecessor metric plus the branch metric. A candidate whose true sum exceeds 0xFFFF is clamped to 0xFFFF and does not wrap.
- R3: When neither predecessor metric is 0xFFFF, `out_metric` is the smaller candidate. `out_dec` is 1 when the lower candidate was chosen and 0 when the upper one was chosen.
- R4: When neither predecessor is 0xFFFF and the two candidates are equal, the upper candidate is chosen and `out_dec` is 0.
- R5: When only the upper predecessor metric is 0xFFFF, the result is the lower candidate, `out_dec` is 1 and `out_gate` is 1.
- R6: When only the lower predecessor metric is 0xFFFF, the result is the upper candidate, `out_dec` is 0 and `out_gate` is 1.
- R7: When both predecessor metrics are 0xFFFF, `out_metric` is 0xFFFF, `out_dec` is 0 and `out_gate` is 1.
- R8: When neither predecessor metric is 0xFFFF, `out_gate` is 0 with the result. This holds even if a candidate sum clamps.
- R9: A synchronous active-high reset drops every operation in flight. No result appears after reset until a new operation has been accepted and has passed through the full latency.
- R10: `out_gate` is asserted only in cycles where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on the inputs are accepted this cycle |
| in_pm_upper | input | 16 | Upper predecessor path metric |
| in_pm_lower | input | 16 | Lower predecessor path metric |
| in_bm_upper | input | 16 | Branch metric on the upper transition |
| in_bm_lower | input | 16 | Branch metric on the lower transition |
| out_valid | output | 1 | A result is present |
| out_metric | output | 16 | Surviving path metric |
| out_dec | output | 1 | Decision: 0 = upper predecessor, 1 = lower predecessor |
| out_gate | output | 1 | The shortcut path was used for this result |

## Verification
The checker tracks the valid flag and the saturation class of each accepted operation in its own delay line, so several behaviours are checked on every cycle. These are the fixed latency, reset flushing, the absence of `out_gate` without a result, the all-ones result when both predecessors saturate, and a clear gating flag when neither does. The arithmetic itself is shown only by the bench's scenarios. These cover clamping sums, ties, the single-saturation cases in both directions, and a mixed stream compared against an independent model. The same applies to dropping operations when reset arrives mid-stream.

// File: rtl/acs_pkg.sv
package acs_pkg;

    parameter int unsigned METRIC_W = 16;
    parameter int unsigned LAT_DEF  = 8;

    typedef logic [METRIC_W-1:0] metric_t;
    localparam metric_t METRIC_CEIL = '1;

    typedef struct packed {
        metric_t pm_up;
        metric_t pm_lo;
        metric_t bm_up;
        metric_t bm_lo;
    } acs_ops_t;

    typedef enum logic [1:0] {
        PICK_CMP   = 2'd0,
        PICK_UPPER = 2'd1,
        PICK_LOWER = 2'd2,
        PICK_CEIL  = 2'd3
    } pick_t;

    typedef struct packed {
        metric_t metric;
        logic    dec;
        logic    gate;
    } acs_res_t;

    function automatic pick_t classify(input logic up_sat, input logic lo_sat);
        if (up_sat && lo_sat) return PICK_CEIL;
        if (up_sat)           return PICK_LOWER;
        if (lo_sat)           return PICK_UPPER;
        return PICK_CMP;
    endfunction

endpackage

// File: rtl/acs_ovf_detect.sv
module acs_ovf_detect
    import acs_pkg::*;
(
    input  acs_ops_t ops,
    output pick_t    pick
);
    logic up_sat;
    logic lo_sat;

    always_comb begin
        up_sat = (ops.pm_up == METRIC_CEIL);
        lo_sat = (ops.pm_lo == METRIC_CEIL);
        pick   = classify(up_sat, lo_sat);
    end
endmodule

// File: rtl/acs_sat_add.sv
module acs_sat_add #(
    parameter int unsigned W = 16
) (
    input  logic         en,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W-1:0] a_iso;
    logic [W-1:0] b_iso;
    logic [W:0]   wide;

    always_comb begin
        a_iso = en ? a : '0;
        b_iso = en ? b : '0;
        wide  = {1'b0, a_iso} + {1'b0, b_iso};
        sum   = wide[W] ? {W{1'b1}} : wide[W-1:0];
    end
endmodule

// File: rtl/acs_select.sv
module acs_select
    import acs_pkg::*;
(
    input  pick_t    pick,
    input  metric_t  cand_up,
    input  metric_t  cand_lo,
    output acs_res_t res
);
    logic cmp_en;
    logic lo_wins;

    always_comb begin
        cmp_en  = (pick == PICK_CMP);
        lo_wins = cmp_en ? (cand_lo < cand_up) : 1'b0;
        unique case (pick)
            PICK_CMP:   res = '{metric: lo_wins ? cand_lo : cand_up, dec: lo_wins, gate: 1'b0};
            PICK_UPPER: res = '{metric: cand_up, dec: 1'b0, gate: 1'b1};
            PICK_LOWER: res = '{metric: cand_lo, dec: 1'b1, gate: 1'b1};
            default:    res = '{metric: METRIC_CEIL, dec: 1'b0, gate: 1'b1};
        endcase
    end
endmodule

// File: rtl/acs_pipe_unit.sv
module acs_pipe_unit
    import acs_pkg::*;
#(
    parameter int unsigned LAT_CYC = LAT_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [METRIC_W-1:0] in_pm_upper,
    input  logic [METRIC_W-1:0] in_pm_lower,
    input  logic [METRIC_W-1:0] in_bm_upper,
    input  logic [METRIC_W-1:0] in_bm_lower,
    output logic                out_valid,
    output logic [METRIC_W-1:0] out_metric,
    output logic                out_dec,
    output logic                out_gate
);
    localparam int unsigned HEAD = 3;
    localparam int unsigned TAIL = LAT_CYC - HEAD;

    acs_ops_t in_ops;
    pick_t    pick_d;
    assign in_ops = '{pm_up: in_pm_upper, pm_lo: in_pm_lower,
                      bm_up: in_bm_upper, bm_lo: in_bm_lower};

    // stage 1: overflow detect
    logic     s1_v;
    acs_ops_t s1_ops;
    pick_t    s1_pick;

    acs_ovf_detect u_det (.ops(in_ops), .pick(pick_d));

    always_ff @(posedge clk) begin
        if (rst) s1_v <= 1'b0;
        else     s1_v <= in_valid;
        s1_ops  <= in_ops;
        s1_pick <= pick_d;
    end

    // stage 2: saturating adders with operand isolation
    logic    en_up;
    logic    en_lo;
    metric_t sum_up;
    metric_t sum_lo;
    logic    s2_v;
    pick_t   s2_pick;
    metric_t s2_up;
    metric_t s2_lo;

    assign en_up = (s1_pick == PICK_CMP) || (s1_pick == PICK_UPPER);
    assign en_lo = (s1_pick == PICK_CMP) || (s1_pick == PICK_LOWER);

    acs_sat_add #(.W(METRIC_W)) u_add_up (.en(en_up), .a(s1_ops.pm_up), .b(s1_ops.bm_up), .sum(sum_up));
    acs_sat_add #(.W(METRIC_W)) u_add_lo (.en(en_lo), .a(s1_ops.pm_lo), .b(s1_ops.bm_lo), .sum(sum_lo));

    always_ff @(posedge clk) begin
        if (rst) s2_v <= 1'b0;
        else     s2_v <= s1_v;
        s2_pick <= s1_pick;
        s2_up   <= sum_up;
        s2_lo   <= sum_lo;
    end

    // stage 3: compare and select
    acs_res_t sel_res;
    logic     s3_v;
    acs_res_t s3_res;

    acs_select u_sel (.pick(s2_pick), .cand_up(s2_up), .cand_lo(s2_lo), .res(sel_res));

    always_ff @(posedge clk) begin
        if (rst) s3_v <= 1'b0;
        else     s3_v <= s2_v;
        s3_res <= sel_res;
    end

    // remaining stages: balancing delay
    logic     fin_v;
    acs_res_t fin_res;

    generate
        if (TAIL == 0) begin : g_no_tail
            assign fin_v   = s3_v;
            assign fin_res = s3_res;
        end else begin : g_tail
            logic     tv [TAIL];
            acs_res_t tr [TAIL];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < TAIL; i++) tv[i] <= 1'b0;
                end else begin
                    tv[0] <= s3_v;
                    for (int i = 1; i < TAIL; i++) tv[i] <= tv[i-1];
                end
                tr[0] <= s3_res;
                for (int i = 1; i < TAIL; i++) tr[i] <= tr[i-1];
            end
            assign fin_v   = tv[TAIL-1];
            assign fin_res = tr[TAIL-1];
        end
    endgenerate

    assign out_valid  = fin_v;
    assign out_metric = fin_res.metric;
    assign out_dec    = fin_res.dec;
    assign out_gate   = fin_v & fin_res.gate;
endmodule

// File: rtl/acs_pipe_chk.sv
module acs_pipe_chk
    import acs_pkg::*;
#(
    parameter int unsigned LAT_CYC = LAT_DEF
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [METRIC_W-1:0] in_pm_upper,
    input logic [METRIC_W-1:0] in_pm_lower,
    input logic                out_valid,
    input logic [METRIC_W-1:0] out_metric,
    input logic                out_dec,
    input logic                out_gate
);
    logic [LAT_CYC-1:0] v_sh;
    logic [LAT_CYC-1:0] both_sh;
    logic [LAT_CYC-1:0] none_sh;
    logic both_in;
    logic none_in;

    assign both_in = (in_pm_upper == METRIC_CEIL) && (in_pm_lower == METRIC_CEIL);
    assign none_in = (in_pm_upper != METRIC_CEIL) && (in_pm_lower != METRIC_CEIL);

    always_ff @(posedge clk) begin
        if (rst) v_sh <= '0;
        else     v_sh <= {v_sh[LAT_CYC-2:0], in_valid};
        both_sh <= {both_sh[LAT_CYC-2:0], both_in};
        none_sh <= {none_sh[LAT_CYC-2:0], none_in};
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_sh[LAT_CYC-1]);

    p_both_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && both_sh[LAT_CYC-1]) |-> (out_metric == METRIC_CEIL && !out_dec && out_gate));

    p_no_gate_clean_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && none_sh[LAT_CYC-1]) |-> !out_gate);

    p_flush_r9: assert property (@(posedge clk)
        rst |=> !out_valid);

    p_gate_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
        out_gate |-> out_valid);
endmodule

bind acs_pipe_unit acs_pipe_chk #(.LAT_CYC(LAT_CYC)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_pm_upper(in_pm_upper), .in_pm_lower(in_pm_lower),
    .out_valid(out_valid), .out_metric(out_metric),
    .out_dec(out_dec), .out_gate(out_gate)
);

// File: tb/acs_pipe_unit_bench.sv
module acs_pipe_unit_bench;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] pm_u = '0, pm_l = '0, bm_u = '0, bm_l = '0;
    logic        out_valid, out_dec, out_gate;
    logic [15:0] out_metric;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] m;
        logic        d;
        logic        g;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    acs_pipe_unit u_acs_pipe_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_pm_upper(pm_u), .in_pm_lower(pm_l),
        .in_bm_upper(bm_u), .in_bm_lower(bm_l),
        .out_valid(out_valid), .out_metric(out_metric),
        .out_dec(out_dec), .out_gate(out_gate)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] clamp_add(input logic [15:0] a, input logic [15:0] b);
        int s;
        s = int'(a) + int'(b);
        return (s > 65535) ? 16'hFFFF : s[15:0];
    endfunction

    task automatic push_op(input logic [15:0] a, input logic [15:0] b,
                           input logic [15:0] c, input logic [15:0] d);
        exp_t e;
        logic [15:0] cu, cl;
        bit su, sl;
        su = (a == 16'hFFFF);
        sl = (b == 16'hFFFF);
        cu = clamp_add(a, c);
        cl = clamp_add(b, d);
        if (su && sl)      begin e.m = 16'hFFFF; e.d = 0; e.g = 1; e.tag = "R7"; end
        else if (su)       begin e.m = cl; e.d = 1; e.g = 1; e.tag = "R5"; end
        else if (sl)       begin e.m = cu; e.d = 0; e.g = 1; e.tag = "R6"; end
        else if (cl < cu)  begin e.m = cl; e.d = 1; e.g = 0; e.tag = "R3/R8"; end
        else               begin e.m = cu; e.d = 0; e.g = 0; e.tag = (cl == cu) ? "R4/R8" : "R3/R8"; end
        if (!su && !sl && (int'(a) + int'(c) > 65535 || int'(b) + int'(d) > 65535))
            e.tag = {e.tag, "/R2"};
        @(negedge clk);
        pm_u = a; pm_l = b; bm_u = c; bm_l = d; in_valid = 1'b1;
        e.due = cyc + LAT;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!done && out_valid) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R1/R9: unexpected result metric=%h dec=%0d, expected no result", out_metric, out_dec);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_metric !== e.m || out_dec !== e.d || out_gate !== e.g || cyc != e.due) begin
                    n_bad++;
                    $display("FAIL %s/R1: got metric=%h dec=%0d gate=%0d cyc=%0d, expected metric=%h dec=%0d gate=%0d cyc=%0d",
                             e.tag, out_metric, out_dec, out_gate, cyc, e.m, e.d, e.g, e.due);
                end
            end
        end
        if (!done && out_gate && !out_valid) begin
            n_chk++; n_bad++;
            $display("FAIL R10: gate=1 valid=0, expected gate=0");
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (!done && cyc > 20000) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: cyc=%0d, expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic expect_quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            n_chk++;
            if (out_valid !== 1'b0 || out_gate !== 1'b0) begin
                n_bad++;
                $display("FAIL %s: valid=%0d gate=%0d, expected 0 0", tag, out_valid, out_gate);
            end
        end
    endtask

    initial begin
        logic [15:0] x;
        // R9: reset state
        expect_quiet(3, "R9");
        @(negedge clk); rst = 1'b0;
        expect_quiet(LAT + 1, "R9");

        // R3: plain minimum, both directions
        push_op(16'd10, 16'd20, 16'd3, 16'd4);
        push_op(16'd50, 16'd5, 16'd1, 16'd2);
        // R4: tie
        push_op(16'd7, 16'd5, 16'd0, 16'd2);
        // R2: both clamp, tie at ceiling, no gating
        push_op(16'hFFF0, 16'hFFFE, 16'h0020, 16'h0010);
        // R2: upper clamps, lower wins
        push_op(16'hFFF0, 16'd100, 16'h0100, 16'd1);
        // R5
        push_op(16'hFFFF, 16'd30, 16'd0, 16'd5);
        push_op(16'hFFFF, 16'hFFF0, 16'd0, 16'h0040);
        // R6
        push_op(16'd12, 16'hFFFF, 16'd3, 16'd0);
        push_op(16'hFFFE, 16'hFFFF, 16'd9, 16'd9);
        // R7
        push_op(16'hFFFF, 16'hFFFF, 16'd1, 16'd2);
        push_op(16'hFFFF, 16'hFFFF, 16'd0, 16'd0);
        idle(3);

        // mixed stream with gaps
        x = 16'hACE1;
        for (int i = 0; i < 48; i++) begin
            logic [15:0] a, b;
            x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
            a = (i % 7 == 0) ? 16'hFFFF : x;
            b = (i % 5 == 0) ? 16'hFFFF : {x[7:0], x[15:8]};
            push_op(a, b, {8'd0, x[11:4]}, {8'd0, x[3:0], x[15:12]});
            if (i % 6 == 5) idle(2);
        end
        idle(LAT + 4);

        // R9: reset mid-flight drops everything
        push_op(16'd1, 16'd2, 16'd3, 16'd4);
        push_op(16'd5, 16'd6, 16'd7, 16'd8);
        push_op(16'hFFFF, 16'd6, 16'd7, 16'd8);
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        sb.delete();
        @(negedge clk);
        rst = 1'b0;
        expect_quiet(LAT + 2, "R9");

        // R1: operation after reset still works
        push_op(16'd100, 16'd90, 16'd5, 16'd20);
        idle(LAT + 3);

        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R1: %0d results missing, expected 0", sb.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule